// File: doc/BRIEF.md
# Set-Cover Branch-and-Bound Search Engine

This block searches for a minimum-cost cover of a small set-covering instance. The instance is a binary matrix with one row per clause and one column per variable. A row is satisfied when at least one variable marked in it is set to 1. The cost of an assignment is the number of variables set to 1. Software writes the rows through a simple write port, chooses a value order, a pseudo-random seed and an optional cost cap, and then pulses `start_i`.

Internally, an array of per-variable state holders keeps each variable at 0, 1 or unassigned. A combinational clause checker classifies the current partial assignment as covering, violating or undecided. A population counter gives the current cost. The controller walks the search tree depth-first and makes exactly one step per clock: either it assigns the next variable or it backtracks to the deepest variable that still has an untried value. A backtrack returns every deeper variable to unassigned.

A branch is abandoned as soon as a clause is violated or the cost reaches the running bound. The bound starts at the cap plus one and drops to the cost of each cover that is recorded. When backtracking has no variable left to flip, the engine pulses `done_o`. It then presents the found flag, the best cost and the best assignment.

The controller has three states:
- IDLE waits for work.
- RUN searches.
- FINISH lasts one cycle and raises `done_o`.

Its transitions are:
- IDLE→RUN on start.
- RUN→RUN on an assign or on a backtrack that finds a variable to flip.
- RUN→FINISH on a backtrack that finds no variable to flip.
- FINISH→RUN on start.
- FINISH→IDLE otherwise.

Top module: `sc_search_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `found_o` are low, and `best_cost_o` and `best_vec_o` are zero.
- R2: While `busy_o` is low, a write with `wr_en_i` high and `wr_addr_i` below CLAUSES stores `wr_row_i` as that clause row, where bit i marks variable i. While `busy_o` is high, writes are ignored. An all-zero row imposes no constraint.
- R3: Start is honoured in IDLE and FINISH. `busy_o` is high from the cycle after start until the search ends. Start clears the found flag, `best_cost_o` and `best_vec_o`, captures the cap from `limit_i`, and sets the bound to the cap plus one.
- R4: When the search ends, `found_o` is 1 exactly when some cover has cost at most the cap, and `best_cost_o` is then the minimum cost over all covers.
- R5: When `found_o` is 1, `best_vec_o` (bit i set when variable i is 1) covers every nonzero row, and its count of ones equals `best_cost_o`.
- R6: When no cover has cost at or below the cap, `found_o` stays 0 and `best_cost_o` and `best_vec_o` stay zero.
- R7: `order_i` selects which value is tried first at each assignment. 0 tries 0 first and 1 tries 1 first. 2 and 3 take the first value from a 16-bit LFSR loaded from `seed_i` at start, with a zero seed replaced by a fixed nonzero value. Every order gives the same `found_o` and `best_cost_o`.
- R8: Each cycle in RUN performs one step, and variables are assigned in index order. The number of clock edges from the edge that captures start until `done_o` is visible is as follows:
  - 1 for an all-zero matrix.
  - 3 for a single row marking only variable 0, under order 0 or order 1.
  - 5 for a single row marking variables 0 and 1, under order 0.
- R9: `done_o` is a single-cycle pulse. `busy_o` is low while it is high. The results hold until the next start.
- R10: During a search the bound never increases. An assign step raises the cost by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search |
| order_i | input | 2 | Value order: 0 zero-first, 1 one-first, 2/3 pseudo-random |
| seed_i | input | 16 | LFSR seed for pseudo-random order |
| limit_i | input | CW = clog2(VARS+1) | Highest cost accepted |
| wr_en_i | input | 1 | Clause row write strobe |
| wr_addr_i | input | AW = clog2(CLAUSES) | Clause row index |
| wr_row_i | input | VARS | Clause row, bit i marks variable i |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | A cover within the cap was recorded |
| best_cost_o | output | CW | Cost of the best cover |
| best_vec_o | output | VARS | Best assignment, bit i set when variable i is 1 |

## Verification
Start is captured on one edge, and `busy_o` is high from the following cycle. Each search step then takes exactly one more edge, and `done_o` appears on the edge after the final backtrack. The bench therefore drives inputs and samples outputs on falling edges, and counts edges from the start capture until `done_o` is seen. It compares that count with the step counts worked out by hand in R8. Result outputs are read in the `done_o` cycle and compared with a minimum found by enumerating all 64 assignments of a 6-variable, 5-clause configuration. In the same cycle the bench checks that `busy_o` is low, and one edge later it checks that `done_o` has fallen.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // three-valued variable state
    typedef enum logic [1:0] {
        V_X    = 2'b00,
        V_ZERO = 2'b01,
        V_ONE  = 2'b10
    } vval_t;

    // controller states
    typedef enum logic [1:0] {
        S_IDLE   = 2'b00,
        S_RUN    = 2'b01,
        S_FINISH = 2'b10
    } ctl_state_t;

    // value-order encodings on order_i
    localparam logic [1:0] ORD_ZERO_FIRST = 2'd0;
    localparam logic [1:0] ORD_ONE_FIRST  = 2'd1;

    localparam logic [15:0] LFSR_TAPS    = 16'hB400;
    localparam logic [15:0] LFSR_DEFAULT = 16'hACE1;

endpackage

// File: rtl/sc_clause_checker.sv
module sc_clause_checker #(
    parameter int VARS    = 64,
    parameter int CLAUSES = 72
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CLAUSES-1:0][VARS-1:0]    rows_i,
    input  logic [VARS-1:0]                 ones_i,
    input  logic [VARS-1:0]                 zeros_i,
    output logic                            all_sat_o,
    output logic                            any_viol_o
);

    logic [CLAUSES-1:0] sat_vec;
    logic [CLAUSES-1:0] viol_vec;

    for (genvar c = 0; c < CLAUSES; c++) begin : g_clause
        logic live;
        assign live        = |rows_i[c];
        // a marked variable at 1 satisfies the row; an empty row never constrains
        assign sat_vec[c]  = !live || (|(rows_i[c] & ones_i));
        // violated once no marked variable is 1 or still open
        assign viol_vec[c] = live && !(|(rows_i[c] & ~zeros_i));
    end

    assign all_sat_o  = &sat_vec;
    assign any_viol_o = |viol_vec;

    AST_SAT_VIOL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(all_sat_o && any_viol_o)); // R4

endmodule

// File: rtl/sc_lfsr.sv
module sc_lfsr
    import sc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic [15:0] seed_i,
    input  logic        step_i,
    output logic        bit_o
);

    logic [15:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LFSR_DEFAULT;
        end else if (load_i) begin
            state_q <= (seed_i == 16'h0) ? LFSR_DEFAULT : seed_i;
        end else if (step_i) begin
            state_q <= {1'b0, state_q[15:1]} ^ (state_q[0] ? LFSR_TAPS : 16'h0);
        end
    end

    assign bit_o = state_q[0];

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 16'h0); // R7

endmodule

// File: rtl/sc_var_array.sv
module sc_var_array
    import sc_pkg::*;
#(
    parameter int VARS = 64,
    localparam int IW  = (VARS > 1) ? $clog2(VARS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            assign_i,
    input  logic [IW-1:0]   assign_idx_i,
    input  logic            assign_one_i,
    input  logic            flip_i,
    input  logic [IW-1:0]   flip_idx_i,
    output logic [VARS-1:0] ones_o,
    output logic [VARS-1:0] zeros_o,
    output logic [VARS-1:0] alt_o
);

    for (genvar i = 0; i < VARS; i++) begin : g_var
        vval_t val_q;
        logic  alt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= V_X;
                alt_q <= 1'b0;
            end else if (clear_i) begin
                val_q <= V_X;
                alt_q <= 1'b0;
            end else if (assign_i && int'(assign_idx_i) == i) begin
                val_q <= assign_one_i ? V_ONE : V_ZERO;
                alt_q <= 1'b1;
            end else if (flip_i) begin
                if (int'(flip_idx_i) == i) begin
                    val_q <= (val_q == V_ONE) ? V_ZERO : V_ONE;
                    alt_q <= 1'b0;
                end else if (i > int'(flip_idx_i)) begin
                    val_q <= V_X;
                    alt_q <= 1'b0;
                end
            end
        end

        assign ones_o[i]  = (val_q == V_ONE);
        assign zeros_o[i] = (val_q == V_ZERO);
        assign alt_o[i]   = alt_q;
    end

    AST_CLEAR_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ones_o == '0) && (zeros_o == '0) && (alt_o == '0)); // R3

    AST_ALT_IMPLIES_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_o & ~(ones_o | zeros_o)) == '0); // R8

endmodule

// File: rtl/sc_cost_counter.sv
module sc_cost_counter #(
    parameter int VARS = 64,
    localparam int CW  = $clog2(VARS + 1)
) (
    input  logic [VARS-1:0] ones_i,
    output logic [CW-1:0]   cost_o
);

    always_comb begin
        cost_o = '0;
        for (int i = 0; i < VARS; i++) begin
            cost_o = cost_o + CW'(ones_i[i]);
        end
    end

endmodule

// File: rtl/sc_search_engine.sv
module sc_search_engine
    import sc_pkg::*;
#(
    parameter int VARS    = 64,
    parameter int CLAUSES = 72,
    localparam int CW     = $clog2(VARS + 1),
    localparam int AW     = (CLAUSES > 1) ? $clog2(CLAUSES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      order_i,
    input  logic [15:0]     seed_i,
    input  logic [CW-1:0]   limit_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [VARS-1:0] wr_row_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            found_o,
    output logic [CW-1:0]   best_cost_o,
    output logic [VARS-1:0] best_vec_o
);

    localparam int IW = (VARS > 1) ? $clog2(VARS) : 1;
    localparam int DW = $clog2(VARS + 1);
    localparam int BW = CW + 1;

    ctl_state_t state_q, state_d;

    logic [CLAUSES-1:0][VARS-1:0] mat_q;
    logic [DW-1:0]                depth_q;
    logic [BW-1:0]                bound_q;
    logic [CW-1:0]                limit_q;
    logic [1:0]                   order_q;

    logic [VARS-1:0] ones_vec, zeros_vec, alt_vec;
    logic            all_sat, any_viol;
    logic [CW-1:0]   cost;
    logic            rnd_bit;

    logic            take_start;
    logic            in_run;
    logic            at_leaf;
    logic            prune;
    logic            record;
    logic            step_back;
    logic            step_assign;
    logic            bt_any;
    logic [IW-1:0]   bt_idx;
    logic            first_one;

    // ---------------- submodules ----------------
    sc_var_array #(.VARS(VARS)) u_vars (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (take_start),
        .assign_i     (step_assign),
        .assign_idx_i (depth_q[IW-1:0]),
        .assign_one_i (first_one),
        .flip_i       (step_back && bt_any),
        .flip_idx_i   (bt_idx),
        .ones_o       (ones_vec),
        .zeros_o      (zeros_vec),
        .alt_o        (alt_vec)
    );

    sc_clause_checker #(.VARS(VARS), .CLAUSES(CLAUSES)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .rows_i     (mat_q),
        .ones_i     (ones_vec),
        .zeros_i    (zeros_vec),
        .all_sat_o  (all_sat),
        .any_viol_o (any_viol)
    );

    sc_cost_counter #(.VARS(VARS)) u_cost (
        .ones_i (ones_vec),
        .cost_o (cost)
    );

    sc_lfsr u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take_start),
        .seed_i (seed_i),
        .step_i (step_assign),
        .bit_o  (rnd_bit)
    );

    // ---------------- step decision ----------------
    always_comb begin
        in_run      = (state_q == S_RUN);
        take_start  = start_i && (state_q != S_RUN);
        at_leaf     = (depth_q == DW'(VARS));
        prune       = any_viol || ({1'b0, cost} >= bound_q);
        record      = in_run && !prune && all_sat;
        step_back   = in_run && (prune || all_sat || at_leaf);
        step_assign = in_run && !step_back;
        unique case (order_q)
            ORD_ZERO_FIRST: first_one = 1'b0;
            ORD_ONE_FIRST:  first_one = 1'b1;
            default:        first_one = rnd_bit;
        endcase
    end

    // deepest variable with an untried value
    always_comb begin
        bt_any = 1'b0;
        bt_idx = '0;
        for (int i = 0; i < VARS; i++) begin
            if (alt_vec[i]) begin
                bt_any = 1'b1;
                bt_idx = IW'(i);
            end
        end
    end

    // ---------------- controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_RUN;
            S_RUN:    if (step_back && !bt_any) state_d = S_FINISH;
            S_FINISH: state_d = start_i ? S_RUN : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy_o = (state_q == S_RUN);
        done_o = (state_q == S_FINISH);
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mat_q <= '0;
        end else if (!in_run && wr_en_i && int'(wr_addr_i) < CLAUSES) begin
            mat_q[wr_addr_i] <= wr_row_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q     <= '0;
            bound_q     <= '0;
            limit_q     <= '0;
            order_q     <= ORD_ZERO_FIRST;
            found_o     <= 1'b0;
            best_cost_o <= '0;
            best_vec_o  <= '0;
        end else if (take_start) begin
            depth_q     <= '0;
            bound_q     <= {1'b0, limit_i} + BW'(1);
            limit_q     <= limit_i;
            order_q     <= order_i;
            found_o     <= 1'b0;
            best_cost_o <= '0;
            best_vec_o  <= '0;
        end else if (in_run) begin
            if (record) begin
                found_o     <= 1'b1;
                best_cost_o <= cost;
                best_vec_o  <= ones_vec;
                bound_q     <= {1'b0, cost};
            end
            if (step_assign) begin
                depth_q <= depth_q + DW'(1);
            end else if (bt_any) begin
                depth_q <= DW'(bt_idx) + DW'(1);
            end
        end
    end

    // ---------------- assertions ----------------
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o)); // R9

    AST_BOUND_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
        in_run |=> bound_q <= $past(bound_q)); // R10

    AST_ASSIGN_COST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_assign |=> {1'b0, cost} <= {1'b0, $past(cost)} + BW'(1)); // R10

    AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DW'(VARS)); // R8

    AST_FOUND_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> best_cost_o <= limit_q); // R4

    AST_BEST_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> $countones(best_vec_o) == int'(best_cost_o)); // R5

    AST_EMPTY_WHEN_NOT_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !found_o |-> (best_vec_o == '0) && (best_cost_o == '0)); // R6

    AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start_i) |=> $stable(best_vec_o) && $stable(found_o)); // R9

endmodule

// File: tb/sc_search_engine_test.sv
`timescale 1ns/1ps
module sc_search_engine_test;

    localparam int NV = 6;
    localparam int NC = 5;
    localparam int CW = 3;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    order_i = 2'd0;
    logic [15:0]   seed_i = 16'h0;
    logic [CW-1:0] limit_i = 3'd6;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [NV-1:0] wr_row_i = '0;
    logic          busy_o, done_o, found_o;
    logic [CW-1:0] best_cost_o;
    logic [NV-1:0] best_vec_o;

    always #4 clk = ~clk;

    sc_search_engine #(.VARS(NV), .CLAUSES(NC)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .order_i(order_i),
        .seed_i(seed_i), .limit_i(limit_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_row_i(wr_row_i), .busy_o(busy_o),
        .done_o(done_o), .found_o(found_o), .best_cost_o(best_cost_o),
        .best_vec_o(best_vec_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [NV-1:0] m [NC];
    logic [31:0] lcg = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cost(input int lim);
        int best = -1;
        for (int a = 0; a < (1 << NV); a++) begin
            bit ok = 1'b1;
            logic [NV-1:0] v = NV'(a);
            for (int r = 0; r < NC; r++)
                if (m[r] != '0 && (m[r] & v) == '0) ok = 1'b0;
            if (ok && $countones(v) <= lim && (best < 0 || $countones(v) < best))
                best = $countones(v);
        end
        return best;
    endfunction

    function automatic bit is_cover(input logic [NV-1:0] v);
        for (int r = 0; r < NC; r++)
            if (m[r] != '0 && (m[r] & v) == '0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic load_all();
        for (int r = 0; r < NC; r++) begin
            @(negedge clk);
            wr_en_i = 1'b1; wr_addr_i = AW'(r); wr_row_i = m[r];
        end
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done_o && lat < 4000) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
        chk(done_o == 1'b1, "R9", "done seen", int'(done_o), 1);
        chk(busy_o == 1'b0, "R9", "busy low at done", int'(busy_o), 0);
    endtask

    task automatic run(input logic [1:0] ord, input logic [15:0] sd,
                       input int lim, output int lat);
        @(negedge clk);
        order_i = ord; seed_i = sd; limit_i = CW'(lim); start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R3", "busy after start", int'(busy_o), 1);
        wait_done(lat);
    endtask

    task automatic verify(input int lim);
        int e = exp_cost(lim);
        if (e < 0) begin
            chk(found_o == 1'b0, "R6", "found", int'(found_o), 0);
            chk(best_cost_o == '0 && best_vec_o == '0, "R6", "empty result",
                int'(best_vec_o), 0);
        end else begin
            chk(found_o == 1'b1, "R4", "found", int'(found_o), 1);
            chk(int'(best_cost_o) == e, "R4", "min cost", int'(best_cost_o), e);
            chk(is_cover(best_vec_o) && $countones(best_vec_o) == int'(best_cost_o),
                "R5", "best vector", int'(best_vec_o), int'(best_cost_o));
        end
    endtask

    task automatic rand_matrix();
        for (int r = 0; r < NC; r++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            m[r] = lcg[13:8] & lcg[21:16];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o == 0 && done_o == 0, "R1", "busy/done at reset", int'({busy_o, done_o}), 0);
        chk(found_o == 0 && best_cost_o == 0 && best_vec_o == 0, "R1", "results at reset",
            int'(best_vec_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 latency: empty matrix
        for (int r = 0; r < NC; r++) m[r] = '0;
        load_all();
        run(2'd0, 16'h0, 6, lat);
        chk(lat == 1, "R8", "latency empty matrix", lat, 1);
        chk(found_o == 1 && best_cost_o == 0, "R2", "empty rows unconstrained", int'(best_cost_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R9", "done single pulse", int'(done_o), 0);

        // R8 latency: single row on variable 0
        m[0] = 6'b000001;
        load_all();
        run(2'd0, 16'h0, 6, lat);
        chk(lat == 3, "R8", "latency v0 zero-first", lat, 3);
        verify(6);
        run(2'd1, 16'h0, 6, lat);
        chk(lat == 3, "R8", "latency v0 one-first", lat, 3);
        verify(6);
        m[0] = 6'b000011;
        load_all();
        run(2'd0, 16'h0, 6, lat);
        chk(lat == 5, "R8", "latency v0|v1 zero-first", lat, 5);
        chk(best_vec_o == 6'b000010, "R8", "index-order first cover", int'(best_vec_o), 2);

        // R2 writes ignored while busy
        m[0] = 6'b110000; m[1] = 6'b001100; m[2] = 6'b100010; m[3] = 6'b000001; m[4] = '0;
        load_all();
        @(negedge clk);
        order_i = 2'd0; limit_i = 3'd6; start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; wr_en_i = 1'b1; wr_addr_i = '0; wr_row_i = '0;
        @(negedge clk);
        wr_en_i = 1'b0;
        wait_done(lat);
        verify(6);
        run(2'd1, 16'h0, 6, lat);
        chk(int'(best_cost_o) == exp_cost(6), "R2", "row kept after busy write",
            int'(best_cost_o), exp_cost(6));

        // R4 R5 R7 sweep over orders
        for (int k = 0; k < 30; k++) begin
            rand_matrix();
            load_all();
            for (int o = 0; o < 4; o++) begin
                run(2'(o), 16'(k * 977 + o), 6, lat);
                verify(6);
                chk(int'(best_cost_o) == (exp_cost(6) < 0 ? 0 : exp_cost(6)), "R7",
                    "order-independent cost", int'(best_cost_o), exp_cost(6));
            end
        end

        // R6 cap sweep
        for (int k = 0; k < 10; k++) begin
            rand_matrix();
            load_all();
            for (int lim = 0; lim <= NV; lim++) begin
                run(2'(k % 4), 16'(k), lim, lat);
                verify(lim);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule